// File: doc/BRIEF.md
# Static Memory Strobe Timing Sequencer

This block drives the control strobes of an asynchronous static memory port with four chip-select banks. Each bank holds its own timing settings: the gap from chip select to write enable, the gap from chip select to output enable, a minimum read length, and a flag that waives that read length. A small word-addressed register port writes and reads the settings. An access request names a bank and a direction. The block raises that bank's chip select and times the strobe from the bank's settings. It then drops chip select together with the strobe and gives a one-cycle done pulse.

Only one access runs at a time. At the start of each access the sequencer takes a copy of the selected bank's settings, so software can rewrite a bank while an access is in flight without upsetting that access. During a read, an address-change pulse restarts the output-enable gap, so output enable always trails the later of chip select and the newest address.

Register address: `reg_addr[3:2]` selects the bank and `reg_addr[1:0]` selects the field. Field 0 is the write-enable gap, 1 the output-enable gap, 2 the read length, and 3 the configuration word, whose bit 0 waives the read length.

Top module: `smc_strobe_seq`

## Requirements
- R1: Each of the four banks stores its own 4-bit write-enable gap, 4-bit output-enable gap, 4-bit read length and 1-bit waive flag at the addresses given above. All of them reset to 0, and a read returns the stored value with every unused upper bit as 0.
- R2: A register request made in one cycle gets `reg_ready` high in the next cycle, and `reg_rdata` is valid in that same cycle.
- R3: Count the first cycle with chip select high as cycle 0. A write raises `mem_we` in cycle n+1, where n is the bank's write-enable gap. That cycle is the last one of the access: chip select and `mem_we` fall together after it.
- R4: A read raises `mem_oe` in cycle m, where m is the bank's output-enable gap. With m = 0, `mem_oe` rises in cycle 0 together with chip select.
- R5: During a read, an `acc_addr_chg` pulse in cycle a drops `mem_oe` when m > 0 and raises it again in cycle a+1+m. With m = 0, `mem_oe` stays high.
- R6: A read's last cycle is the first cycle that is at least the bank's read length r and in which `mem_oe` is high.
- R7: When a bank's waive flag is set, its read length is treated as 0.
- R8: In the cycle after an access's last cycle, `acc_done` is high for exactly one cycle with every chip select low. A request made while an access or its done cycle is under way is ignored.
- R9: An access uses the settings the bank held when the access started. A register write during the access takes effect from the next access onward.
- R10: `mem_cs` is one-hot on the requested bank for the whole access. `mem_we` appears only on writes, `mem_oe` only on reads, and neither appears without chip select.
- R11: While and right after reset, every chip select, strobe, `acc_done` and `reg_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = register write, 0 = read |
| reg_addr | input | 4 | {bank, field} register word address |
| reg_wdata | input | 32 | Register write data, upper 28 bits must be zero |
| reg_rdata | output | 32 | Register read data, valid with reg_ready |
| reg_ready | output | 1 | Register access complete |
| acc_req | input | 1 | Start an access, honoured only when idle |
| acc_bank | input | 2 | Bank of the requested access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr_chg | input | 1 | Address changed this cycle (reads only) |
| mem_cs | output | 4 | Per-bank chip select, active high |
| mem_we | output | 1 | Write enable strobe, active high |
| mem_oe | output | 1 | Output enable strobe, active high |
| acc_done | output | 1 | One-cycle access completion pulse |

## Verification
The assertions assume that register writes leave the upper 28 data bits at zero, that register requests last one cycle, and that an address-change pulse is only raised while a read is active. The bench keeps to these rules. Its random values are masked to four bits before they are written, and it raises `acc_addr_chg` only inside a read, in a cycle drawn below the read's unchanged end so that the pulse always lands before the access finishes. Requests are issued from idle, except in the one directed case that checks a request made while the block is busy is ignored.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    FLD_WE_GAP = 2'd0,
    FLD_OE_GAP = 2'd1,
    FLD_RD_LEN = 2'd2,
    FLD_CFG    = 2'd3
  } reg_field_e;

  // Cycles from chip select to write enable: the field plus one.
  function automatic int we_gap_cycles(input int field);
    return field + 1;
  endfunction

  // Cycles from reference point to output enable: the field itself.
  function automatic int oe_gap_cycles(input int field);
    return field;
  endfunction

  // Minimum read length, waived by the configuration flag.
  function automatic int rd_len_cycles(input int field, input bit waive);
    return waive ? 0 : field;
  endfunction

endpackage

// File: rtl/smc_delay_counter.sv
module smc_delay_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // Counter never wraps: once expired it stays expired until reloaded.
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/smc_timing_regs.sv
module smc_timing_regs #(
  parameter int NUM_BANKS = 4,
  parameter int FIELD_W   = 4,
  parameter int DATA_W    = 32,
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int REG_AW   = BANK_AW + 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_req,
  input  logic                         reg_we,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic                         reg_ready,
  output logic [NUM_BANKS*FIELD_W-1:0] we_gap_all,
  output logic [NUM_BANKS*FIELD_W-1:0] oe_gap_all,
  output logic [NUM_BANKS*FIELD_W-1:0] rd_len_all,
  output logic [NUM_BANKS-1:0]         waive_all
);
  import smc_pkg::*;

  logic [BANK_AW-1:0] sel_bank;
  reg_field_e         sel_field;
  logic               wr_req;
  logic [DATA_W-1:0]  rd_word;
  logic [DATA_W-1:0]  rdata_q;
  logic               ready_q;

  assign sel_bank  = reg_addr[REG_AW-1:2];
  assign sel_field = reg_field_e'(reg_addr[1:0]);
  assign wr_req    = reg_req && reg_we;

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic               hit;
    logic [FIELD_W-1:0] we_gap_q, oe_gap_q, rd_len_q;
    logic               waive_q;

    assign hit = wr_req && (sel_bank == BANK_AW'(gb));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        we_gap_q <= '0;
        oe_gap_q <= '0;
        rd_len_q <= '0;
        waive_q  <= 1'b0;
      end else if (hit) begin
        case (sel_field)
          FLD_WE_GAP: we_gap_q <= reg_wdata[FIELD_W-1:0];
          FLD_OE_GAP: oe_gap_q <= reg_wdata[FIELD_W-1:0];
          FLD_RD_LEN: rd_len_q <= reg_wdata[FIELD_W-1:0];
          default:    waive_q  <= reg_wdata[0];
        endcase
      end
    end

    assign we_gap_all[gb*FIELD_W +: FIELD_W] = we_gap_q;
    assign oe_gap_all[gb*FIELD_W +: FIELD_W] = oe_gap_q;
    assign rd_len_all[gb*FIELD_W +: FIELD_W] = rd_len_q;
    assign waive_all[gb]                     = waive_q;
  end

  always_comb begin
    rd_word = '0;
    case (sel_field)
      FLD_WE_GAP: rd_word[FIELD_W-1:0] = we_gap_all[int'(sel_bank)*FIELD_W +: FIELD_W];
      FLD_OE_GAP: rd_word[FIELD_W-1:0] = oe_gap_all[int'(sel_bank)*FIELD_W +: FIELD_W];
      FLD_RD_LEN: rd_word[FIELD_W-1:0] = rd_len_all[int'(sel_bank)*FIELD_W +: FIELD_W];
      default:    rd_word[0]           = waive_all[sel_bank];
    endcase
  end

  // One wait state: response registered one cycle after the request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= reg_req;
      rdata_q <= reg_req ? rd_word : '0;
    end
  end

  assign reg_ready = ready_q;
  assign reg_rdata = rdata_q;

  assert_ready_one_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> reg_ready);
  assert_ready_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ready |-> $past(reg_req));
  assert_upper_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ready |-> (reg_rdata[DATA_W-1:FIELD_W] == '0));
  // Input assumption: software leaves the unused write bits at zero.
  assert_wdata_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (reg_wdata[DATA_W-1:FIELD_W] == '0));
endmodule

// File: rtl/smc_strobe_ctrl.sv
module smc_strobe_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int FIELD_W   = 4,
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int WE_CW    = FIELD_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_req,
  input  logic [BANK_AW-1:0]           acc_bank,
  input  logic                         acc_write,
  input  logic                         acc_addr_chg,
  input  logic [NUM_BANKS*FIELD_W-1:0] we_gap_all,
  input  logic [NUM_BANKS*FIELD_W-1:0] oe_gap_all,
  input  logic [NUM_BANKS*FIELD_W-1:0] rd_len_all,
  input  logic [NUM_BANKS-1:0]         waive_all,
  output logic [NUM_BANKS-1:0]         mem_cs,
  output logic                         mem_we,
  output logic                         mem_oe,
  output logic                         acc_done
);
  import smc_pkg::*;

  seq_state_e         st_q, st_d;
  logic [BANK_AW-1:0] bank_q;
  logic               write_q;
  logic [FIELD_W-1:0] oe_gap_snap_q;

  // Named internal events used by the assertions.
  logic               start_evt;
  logic               active;
  logic               oe_restart_evt;
  logic               access_end_evt;
  logic               we_expired, oe_expired, rd_expired;

  logic [FIELD_W-1:0] sel_we_gap, sel_oe_gap, sel_rd_len;
  logic               sel_waive;
  logic [WE_CW-1:0]   we_load_val;
  logic [FIELD_W-1:0] oe_load_val, rd_load_val;

  assign sel_we_gap = we_gap_all[int'(acc_bank)*FIELD_W +: FIELD_W];
  assign sel_oe_gap = oe_gap_all[int'(acc_bank)*FIELD_W +: FIELD_W];
  assign sel_rd_len = rd_len_all[int'(acc_bank)*FIELD_W +: FIELD_W];
  assign sel_waive  = waive_all[acc_bank];

  assign active         = (st_q == ST_ACTIVE);
  assign start_evt      = (st_q == ST_IDLE) && acc_req;
  assign oe_restart_evt = active && !write_q && acc_addr_chg;

  assign we_load_val = WE_CW'(we_gap_cycles(int'(sel_we_gap)));
  assign oe_load_val = start_evt ? FIELD_W'(oe_gap_cycles(int'(sel_oe_gap))) : oe_gap_snap_q;
  assign rd_load_val = FIELD_W'(rd_len_cycles(int'(sel_rd_len), sel_waive));

  smc_delay_counter #(.W(WE_CW)) u_we_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_val(we_load_val),
    .run(active), .expired(we_expired));

  smc_delay_counter #(.W(FIELD_W)) u_oe_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_evt || oe_restart_evt), .load_val(oe_load_val),
    .run(active), .expired(oe_expired));

  smc_delay_counter #(.W(FIELD_W)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_val(rd_load_val),
    .run(active), .expired(rd_expired));

  assign mem_we = active && write_q && we_expired;
  assign mem_oe = active && !write_q && oe_expired;
  assign access_end_evt = write_q ? mem_we : (mem_oe && rd_expired);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (acc_req) st_d = ST_ACTIVE;
      ST_ACTIVE: if (access_end_evt) st_d = ST_DONE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      bank_q        <= '0;
      write_q       <= 1'b0;
      oe_gap_snap_q <= '0;
    end else begin
      st_q <= st_d;
      if (start_evt) begin
        bank_q        <= acc_bank;
        write_q       <= acc_write;
        oe_gap_snap_q <= sel_oe_gap;
      end
    end
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_cs
    assign mem_cs[gb] = active && (bank_q == BANK_AW'(gb));
  end

  assign acc_done = (st_q == ST_DONE);

  assert_cs_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_cs));
  assert_strobe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_oe) |-> (mem_cs != '0));
  assert_we_oe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_oe));
  assert_cs_bank_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cs != '0) && !access_end_evt) |=> (mem_cs == $past(mem_cs)));
  assert_we_not_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !mem_we);
  assert_we_ends_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (acc_done && mem_cs == '0 && !mem_we));
  assert_oe_zero_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !acc_write && sel_oe_gap == '0) |=> mem_oe);
  assert_restart_drops_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_restart_evt && !access_end_evt && oe_gap_snap_q != '0) |=> !mem_oe);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> (!acc_done && mem_cs == '0));
endmodule

// File: rtl/smc_strobe_seq.sv
module smc_strobe_seq #(
  parameter int NUM_BANKS = 4,
  parameter int FIELD_W   = 4,
  parameter int DATA_W    = 32,
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int REG_AW   = BANK_AW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_ready,
  input  logic                 acc_req,
  input  logic [BANK_AW-1:0]   acc_bank,
  input  logic                 acc_write,
  input  logic                 acc_addr_chg,
  output logic [NUM_BANKS-1:0] mem_cs,
  output logic                 mem_we,
  output logic                 mem_oe,
  output logic                 acc_done
);
  logic [NUM_BANKS*FIELD_W-1:0] we_gap_all, oe_gap_all, rd_len_all;
  logic [NUM_BANKS-1:0]         waive_all;

  smc_timing_regs #(.NUM_BANKS(NUM_BANKS), .FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .we_gap_all(we_gap_all), .oe_gap_all(oe_gap_all),
    .rd_len_all(rd_len_all), .waive_all(waive_all));

  smc_strobe_ctrl #(.NUM_BANKS(NUM_BANKS), .FIELD_W(FIELD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .acc_req(acc_req), .acc_bank(acc_bank), .acc_write(acc_write),
    .acc_addr_chg(acc_addr_chg),
    .we_gap_all(we_gap_all), .oe_gap_all(oe_gap_all),
    .rd_len_all(rd_len_all), .waive_all(waive_all),
    .mem_cs(mem_cs), .mem_we(mem_we), .mem_oe(mem_oe), .acc_done(acc_done));
endmodule

// File: tb/tb_smc_strobe_seq.sv
`timescale 1ns/1ps
module tb_smc_strobe_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ready;
  logic        acc_req = 1'b0, acc_write = 1'b0, acc_addr_chg = 1'b0;
  logic [1:0]  acc_bank = '0;
  logic [3:0]  mem_cs;
  logic        mem_we, mem_oe, acc_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  smc_strobe_seq dut (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .acc_req(acc_req), .acc_bank(acc_bank), .acc_write(acc_write),
    .acc_addr_chg(acc_addr_chg),
    .mem_cs(mem_cs), .mem_we(mem_we), .mem_oe(mem_oe), .acc_done(acc_done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bench model: last read cycle from the gap, read length and change cycle.
  function automatic int model_read_last(input int m, input int r, input int ta);
    for (int t = 0; t < 200; t++) begin
      bit hi;
      if (ta >= 0 && t > ta) hi = (t >= ta + 1 + m);
      else                   hi = (t >= m);
      if (hi && t >= r) return t;
    end
    return -1;
  endfunction

  function automatic int model_oe_last_rise(input int m, input int ta);
    if (m == 0) return 0;
    if (ta < 0) return m;
    return ta + 1 + m;
  endfunction

  task automatic reg_write(input int bank, input int field, input int val);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1;
    reg_addr = 4'((bank << 2) | field); reg_wdata = 32'(val);
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    check(reg_ready === 1'b1, "R2 write ready", int'(reg_ready), 1);
  endtask

  task automatic reg_read(input int bank, input int field, output int val);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = 4'((bank << 2) | field);
    @(negedge clk);
    reg_req = 1'b0;
    check(reg_ready === 1'b1, "R2 read ready", int'(reg_ready), 1);
    val = int'(reg_rdata);
  endtask

  task automatic set_bank(input int b, input int wg, input int og, input int rl, input int wv);
    reg_write(b, 0, wg);
    reg_write(b, 1, og);
    reg_write(b, 2, rl);
    reg_write(b, 3, wv);
  endtask

  // Runs one access; cycle 0 is the first sampled cycle with chip select high.
  task automatic run_access(input int bank, input bit wr, input int chg_at,
                            output int we_first, output int oe_rise, output int len,
                            output bit done_ok, output bit shape_ok);
    bit prev_oe = 1'b0;
    int t = 0;
    we_first = -1; oe_rise = -1; shape_ok = 1'b1;
    @(negedge clk);
    acc_req = 1'b1; acc_bank = 2'(bank); acc_write = wr;
    @(negedge clk);
    acc_req = 1'b0;
    while (mem_cs != 4'b0 && t < 100) begin
      if (mem_cs !== 4'(1 << bank)) shape_ok = 1'b0;
      if (wr && mem_oe) shape_ok = 1'b0;
      if (!wr && mem_we) shape_ok = 1'b0;
      if (mem_we && we_first < 0) we_first = t;
      if (mem_oe && !prev_oe) oe_rise = t;
      prev_oe = mem_oe;
      acc_addr_chg = (t == chg_at);
      @(negedge clk);
      acc_addr_chg = 1'b0;
      t++;
    end
    len = t;
    done_ok = (acc_done === 1'b1);
  endtask

  task automatic check_write(input int b, input int n, input string tag);
    int wf, orr, ln; bit dn, sh;
    run_access(b, 1'b1, -1, wf, orr, ln, dn, sh);
    check(wf == n + 1, {tag, " we gap"}, wf, n + 1);
    check(ln == n + 2, {tag, " write length"}, ln, n + 2);
    check(dn, "R8 done after write", int'(dn), 1);
    check(sh, "R10 write strobe shape", int'(sh), 1);
  endtask

  task automatic check_read(input int b, input int m, input int r, input int ta, input string tag);
    int wf, orr, ln, ex; bit dn, sh;
    run_access(b, 1'b0, ta, wf, orr, ln, dn, sh);
    ex = model_read_last(m, r, ta) + 1;
    check(orr == model_oe_last_rise(m, ta), {tag, " oe rise"}, orr, model_oe_last_rise(m, ta));
    check(ln == ex, {tag, " read length"}, ln, ex);
    check(dn, "R8 done after read", int'(dn), 1);
    check(sh, "R10 read strobe shape", int'(sh), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int v;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R11: reset state
    check(mem_cs == 4'b0 && !mem_we && !mem_oe && !acc_done && !reg_ready,
          "R11 outputs low in reset", int'({mem_cs, mem_we, mem_oe, acc_done, reg_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_cs == 4'b0 && !acc_done, "R11 outputs low after reset",
          int'({mem_cs, acc_done}), 0);

    // R1: reset values and upper bits
    for (int b = 0; b < 4; b++)
      for (int f = 0; f < 4; f++) begin
        reg_read(b, f, v);
        check(v == 0, "R1 reset value", v, 0);
      end

    // R1: independent storage per bank and field
    for (int b = 0; b < 4; b++) set_bank(b, 15 - b, 4 + b, 8 + b, b & 1);
    for (int b = 0; b < 4; b++) begin
      reg_read(b, 0, v); check(v == 15 - b, "R1 we gap readback", v, 15 - b);
      reg_read(b, 1, v); check(v == 4 + b,  "R1 oe gap readback", v, 4 + b);
      reg_read(b, 2, v); check(v == 8 + b,  "R1 read length readback", v, 8 + b);
      reg_read(b, 3, v); check(v == (b & 1), "R1 waive readback", v, b & 1);
    end

    // R3 R4 R6 R7: sweep every field value on every bank
    for (int b = 0; b < 4; b++)
      for (int n = 0; n < 16; n++) begin
        int m, r, w;
        m = (n * 7 + b) & 15;
        r = int'($urandom % 16);
        w = int'($urandom % 2);
        set_bank(b, n, m, r, w);
        check_write(b, n, "R3");
        check_read(b, m, (w != 0) ? 0 : r, -1, (w != 0) ? "R7" : "R4 R6");
      end

    // R7: directed waive with a long read length
    set_bank(2, 0, 0, 15, 1);
    check_read(2, 0, 0, -1, "R7 waived");
    set_bank(2, 0, 0, 15, 0);
    check_read(2, 0, 15, -1, "R6 full length");

    // R5: address-change restarts, random mix plus corners
    for (int i = 0; i < 40; i++) begin
      int b, m, r, w, ta, base;
      b = int'($urandom % 4);
      m = int'($urandom % 16);
      r = int'($urandom % 16);
      w = int'($urandom % 2);
      if (i == 0) begin m = 0; r = 9; w = 0; end
      if (i == 1) begin m = 3; r = 12; w = 0; end
      set_bank(b, 1, m, r, w);
      base = model_read_last(m, (w != 0) ? 0 : r, -1);
      ta = (i == 1) ? 5 : int'($urandom % (base + 1));
      if (ta >= base) ta = base - 1;
      if (ta < 0) ta = -1;
      check_read(b, m, (w != 0) ? 0 : r, ta, "R5");
    end

    // R9: rewrite during an access only affects the next one
    set_bank(1, 10, 0, 0, 0);
    begin
      int wf, orr, ln; bit dn, sh;
      fork
        run_access(1, 1'b1, -1, wf, orr, ln, dn, sh);
        begin repeat (4) @(negedge clk); reg_write(1, 0, 2); end
      join
      check(wf == 11, "R9 in-flight write unaffected", wf, 11);
      check(ln == 12, "R9 in-flight length unaffected", ln, 12);
    end
    check_write(1, 2, "R9 next access");

    // R8: request while busy is ignored
    set_bank(3, 5, 0, 0, 0);
    set_bank(0, 0, 0, 0, 0);
    begin
      int wf, orr, ln; bit dn, sh;
      fork
        run_access(3, 1'b1, -1, wf, orr, ln, dn, sh);
        begin
          repeat (3) @(negedge clk);
          acc_req = 1'b1; acc_bank = 2'd0; acc_write = 1'b0;
          @(negedge clk);
          acc_req = 1'b0; acc_bank = 2'd3; acc_write = 1'b1;
        end
      join
      check(wf == 6, "R8 busy request ignored, write timing", wf, 6);
      check(sh, "R8 busy request ignored, bank kept", int'(sh), 1);
      @(negedge clk);
      check(!acc_done, "R8 done is one cycle", int'(acc_done), 0);
      for (int k = 0; k < 3; k++) begin
        check(mem_cs == 4'b0, "R8 no access started from busy request", int'(mem_cs), 0);
        @(negedge clk);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule